// File: doc/BRIEF.md
# Receive Rate Adapter with Start-of-Frame Nibble Realignment

This block sits in the 125 MHz reference clock domain. On one side is a serial-gigabit PCS receive path. On the other side is the 8-bit GMII receive port of a client MAC. At lower link speeds the PCS holds each receive byte, together with its valid and error flags, for many reference cycles: 10 cycles at 100 Mb/s and 100 cycles at 10 Mb/s. The adapter takes one sample of each symbol, in the cycle where a speed clock enable is high. At 1 Gb/s it takes a new byte in every cycle. The client MAC samples the GMII outputs on the rising edge, qualified by the same enable.

The adapter also searches each frame for the start-of-frame delimiter, 0xD5, which follows a run of 0x55 preamble bytes. A far end with a 4-bit datapath can shift the delimiter by one nibble, so that it straddles two bytes. The adapter recognises that case and rebuilds every byte for the rest of the frame from two adjacent input bytes. The client then receives a correctly aligned delimiter and correctly aligned payload.

A two-bit speed code tells the adapter when to ignore the enable and sample in every cycle. Generating the enable and decoding the PCS are left to neighbouring blocks.

Top module: `rx_rate_adapt`

## Requirements
- R1: While reset is asserted, and until the first sampling edge after reset, gmii_rxd, gmii_rx_dv and gmii_rx_er are all zero.
- R2: With speed code 2'b10 (1 Gb/s), inputs are sampled at every rising edge whatever the value of sample_en.
- R3: With speed codes 2'b00 (10 Mb/s), 2'b01 (100 Mb/s) and 2'b11 (reserved, treated like the slow codes), inputs are sampled only at edges where sample_en is high. Outputs change only at those edges, and input values in other cycles have no effect.
- R4: Outside a shifted frame, a byte sampled at one sampling edge appears on gmii_rxd right after the next sampling edge.
- R5: A valid preamble byte 0x55 followed by a valid 0xD5 passes through unchanged and fixes the frame as unshifted.
- R6: While searching, a valid 0x55 followed by a valid byte whose bits [3:0] are 0xD (and which is not 0xD5) switches the frame to shifted mode. In shifted mode each output byte takes bits [3:0] of the current sample into bits [7:4] and bits [7:4] of the previous sample into bits [3:0]. The straddling byte itself is rebuilt this way, so it appears as 0xD5.
- R7: Shifted mode lasts as long as rx_dv_in is sampled high. A sample with rx_dv_in low returns the adapter to unshifted search, so the next frame starts unshifted.
- R8: gmii_rx_dv and gmii_rx_er carry the rx_dv_in and rx_er_in of the previous sample, with the same latency as the data, and are never changed by shifted mode.
- R9: Once a frame is fixed as shifted or unshifted, later 0x55 / 0xD-low-nibble patterns in that frame cause no change in alignment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| speed_sel | input | 2 | Link speed code: 00 = 10 Mb/s, 01 = 100 Mb/s, 10 = 1 Gb/s |
| sample_en | input | 1 | Speed clock enable marking the cycle in which to sample a symbol |
| rx_data_in | input | 8 | Receive byte from the PCS |
| rx_dv_in | input | 1 | Receive data valid from the PCS |
| rx_er_in | input | 1 | Receive error from the PCS |
| gmii_rxd | output | 8 | GMII receive data to the client MAC |
| gmii_rx_dv | output | 1 | GMII receive data valid |
| gmii_rx_er | output | 1 | GMII receive error |

## Verification
The bench builds the adapter with its default parameters: an 8-bit datapath, preamble 0x55, delimiter 0xD5, and the 1 Gb/s enable override switched on. With these defaults the nibble-skew path and the enable override can both be exercised with short, hand-written frames at all three speeds and with the reserved code. At the slow speeds the bench drives changing garbage into every cycle that is not enabled. A missed or extra sample therefore shows up as a wrong byte rather than as a repeated copy of a held value.

// File: rtl/rxra_pkg.sv
package rxra_pkg;
   typedef enum logic [1:0] {
      SPD_10M   = 2'b00,
      SPD_100M  = 2'b01,
      SPD_1000M = 2'b10,
      SPD_RSVD  = 2'b11
   } rxra_speed_e;
endpackage

// File: rtl/rxra_sample_gate.sv
module rxra_sample_gate #(
   parameter bit GIG_BYPASS = 1'b1
) (
   input  logic [1:0] speed_sel,
   input  logic       sample_en,
   output logic       samp_en
);
   import rxra_pkg::*;

   generate
      if (GIG_BYPASS) begin : g_bypass
         // at full rate every cycle carries a new symbol
         assign samp_en = sample_en | (rxra_speed_e'(speed_sel) == SPD_1000M);
      end else begin : g_enable_only
         logic unused_speed;
         assign unused_speed = ^speed_sel;
         assign samp_en      = sample_en;
      end
   endgenerate
endmodule

// File: rtl/rxra_hold_reg.sv
module rxra_hold_reg #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic [DW-1:0] d_in,
   input  logic          dv_in,
   input  logic          er_in,
   output logic [DW-1:0] d_q,
   output logic          dv_q,
   output logic          er_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         d_q  <= '0;
         dv_q <= 1'b0;
         er_q <= 1'b0;
      end else if (en) begin
         d_q  <= d_in;
         dv_q <= dv_in;
         er_q <= er_in;
      end
   end
endmodule

// File: rtl/rxra_sfd_align.sv
module rxra_sfd_align #(
   parameter int          DW       = 8,
   parameter logic [DW-1:0] PRE_BYTE = 8'h55,
   parameter logic [DW-1:0] SFD_BYTE = 8'hD5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic [DW-1:0] cur_d,
   input  logic          cur_dv,
   input  logic [DW-1:0] prv_d,
   input  logic          prv_dv,
   input  logic          prv_er,
   output logic [DW-1:0] out_d,
   output logic          out_dv,
   output logic          out_er,
   output logic          shift_o
);
   localparam int NIB = DW / 2;

   logic          shift_q;  // frame is nibble shifted
   logic          fixed_q;  // alignment decided for this frame
   logic          pre_seen;
   logic          skew_hit;
   logic          sfd_hit;
   logic          use_shift;
   logic [DW-1:0] rebuilt;

   assign pre_seen  = !fixed_q && prv_dv && (prv_d == PRE_BYTE) && cur_dv;
   assign sfd_hit   = pre_seen && (cur_d == SFD_BYTE);
   assign skew_hit  = pre_seen && (cur_d != SFD_BYTE)
                      && (cur_d[NIB-1:0] == SFD_BYTE[DW-1:NIB]);
   assign use_shift = shift_q || skew_hit;
   assign rebuilt   = {cur_d[NIB-1:0], prv_d[DW-1:NIB]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shift_q <= 1'b0;
         fixed_q <= 1'b0;
      end else if (en) begin
         if (!cur_dv) begin
            shift_q <= 1'b0;
            fixed_q <= 1'b0;
         end else if (skew_hit) begin
            shift_q <= 1'b1;
            fixed_q <= 1'b1;
         end else if (sfd_hit) begin
            fixed_q <= 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_d  <= '0;
         out_dv <= 1'b0;
         out_er <= 1'b0;
      end else if (en) begin
         out_d  <= use_shift ? rebuilt : prv_d;
         out_dv <= prv_dv;
         out_er <= prv_er;
      end
   end

   assign shift_o = shift_q;
endmodule

// File: rtl/rx_rate_adapt.sv
module rx_rate_adapt #(
   parameter int            DW         = 8,
   parameter logic [DW-1:0] PRE_BYTE   = 8'h55,
   parameter logic [DW-1:0] SFD_BYTE   = 8'hD5,
   parameter bit            GIG_BYPASS = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    speed_sel,
   input  logic          sample_en,
   input  logic [DW-1:0] rx_data_in,
   input  logic          rx_dv_in,
   input  logic          rx_er_in,
   output logic [DW-1:0] gmii_rxd,
   output logic          gmii_rx_dv,
   output logic          gmii_rx_er
);
   generate
      if ((DW < 4) || (DW % 2 != 0)) begin : g_bad_width
         $error("rx_rate_adapt: DW must be even and at least 4");
      end
      if (PRE_BYTE == SFD_BYTE) begin : g_bad_codes
         $error("rx_rate_adapt: preamble and delimiter codes must differ");
      end
   endgenerate

   logic          samp_en;
   logic [DW-1:0] hold_d;
   logic          hold_dv;
   logic          hold_er;
   logic          shift_act;

   rxra_sample_gate #(.GIG_BYPASS(GIG_BYPASS)) u_gate (
      .speed_sel (speed_sel),
      .sample_en (sample_en),
      .samp_en   (samp_en)
   );

   rxra_hold_reg #(.DW(DW)) u_hold (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (samp_en),
      .d_in  (rx_data_in),
      .dv_in (rx_dv_in),
      .er_in (rx_er_in),
      .d_q   (hold_d),
      .dv_q  (hold_dv),
      .er_q  (hold_er)
   );

   rxra_sfd_align #(.DW(DW), .PRE_BYTE(PRE_BYTE), .SFD_BYTE(SFD_BYTE)) u_align (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (samp_en),
      .cur_d   (rx_data_in),
      .cur_dv  (rx_dv_in),
      .prv_d   (hold_d),
      .prv_dv  (hold_dv),
      .prv_er  (hold_er),
      .out_d   (gmii_rxd),
      .out_dv  (gmii_rx_dv),
      .out_er  (gmii_rx_er),
      .shift_o (shift_act)
   );
endmodule

// File: rtl/rx_rate_adapt_chk.sv
module rx_rate_adapt_chk #(
   parameter int DW         = 8,
   parameter bit GIG_BYPASS = 1'b1
) (
   input logic          clk,
   input logic          rst_n,
   input logic          eff_en,
   input logic          shift_q,
   input logic [1:0]    speed_sel,
   input logic          rx_dv_in,
   input logic          rx_er_in,
   input logic [DW-1:0] gmii_rxd,
   input logic          gmii_rx_dv,
   input logic          gmii_rx_er
);
   logic [1:0] up_cnt;
   logic       gig_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             up_cnt <= 2'd0;
      else if (up_cnt != 2'd3) up_cnt <= up_cnt + 2'd1;
   end

   assign gig_run = GIG_BYPASS && (up_cnt >= 2'd2) && (speed_sel == 2'b10);

   // R3
   hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !eff_en |=> ($stable(gmii_rxd) && $stable(gmii_rx_dv) && $stable(gmii_rx_er)));

   // R2
   gig_dv_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gig_run && $past(speed_sel) == 2'b10 && $past(speed_sel, 2) == 2'b10)
      |-> (gmii_rx_dv == $past(rx_dv_in, 2)));

   // R8
   gig_er_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gig_run && $past(speed_sel) == 2'b10 && $past(speed_sel, 2) == 2'b10)
      |-> (gmii_rx_er == $past(rx_er_in, 2)));

   // R7
   shift_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eff_en && !rx_dv_in) |=> !shift_q);
endmodule

bind rx_rate_adapt rx_rate_adapt_chk #(.DW(DW), .GIG_BYPASS(GIG_BYPASS)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .eff_en     (samp_en),
   .shift_q    (shift_act),
   .speed_sel  (speed_sel),
   .rx_dv_in   (rx_dv_in),
   .rx_er_in   (rx_er_in),
   .gmii_rxd   (gmii_rxd),
   .gmii_rx_dv (gmii_rx_dv),
   .gmii_rx_er (gmii_rx_er)
);

// File: tb/rx_rate_adapt_tb.sv
module rx_rate_adapt_tb;
   localparam int CLK_NS   = 8;
   localparam int MID_PER  = 10;
   localparam int SLOW_PER = 100;
   localparam int WDOG_CYC = 200000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] speed_sel = 2'b00;
   logic       sample_en = 1'b0;
   logic [7:0] rx_data_in = 8'h00;
   logic       rx_dv_in = 1'b0;
   logic       rx_er_in = 1'b0;
   logic [7:0] gmii_rxd;
   logic       gmii_rx_dv;
   logic       gmii_rx_er;

   always #(CLK_NS/2) clk = ~clk;

   rx_rate_adapt u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .speed_sel  (speed_sel),
      .sample_en  (sample_en),
      .rx_data_in (rx_data_in),
      .rx_dv_in   (rx_dv_in),
      .rx_er_in   (rx_er_in),
      .gmii_rxd   (gmii_rxd),
      .gmii_rx_dv (gmii_rx_dv),
      .gmii_rx_er (gmii_rx_er)
   );

   int         n_chk = 0;
   int         n_fail = 0;
   logic [9:0] exp_q[$];
   string      tag_q[$];
   logic [9:0] last_exp = 10'h000;
   logic       tb_eff = 1'b0;
   logic [1:0] cur_spd = 2'b00;
   bit         done = 1'b0;

   // reference model state, built from the requirements
   logic [7:0] m_pd = 8'h00;
   logic       m_pdv = 1'b0;
   logic       m_per = 1'b0;
   int         m_st = 0;   // 0 search, 1 fixed unshifted, 2 shifted

   task automatic check(input string tag, input logic [9:0] act, input logic [9:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got er=%0b dv=%0b d=%02h, expected er=%0b dv=%0b d=%02h",
                  tag, act[9], act[8], act[7:0], exp[9], exp[8], exp[7:0]);
      end
   endtask

   task automatic model_step(input logic [7:0] d, input logic dv, input logic er, input string tag);
      logic       pre;
      logic       skew;
      logic [7:0] od;
      pre  = (m_st == 0) && m_pdv && (m_pd == 8'h55) && dv;
      skew = pre && (d[3:0] == 4'hD) && (d != 8'hD5);
      od   = ((m_st == 2) || skew) ? {d[3:0], m_pd[7:4]} : m_pd;
      exp_q.push_back({m_per, m_pdv, od});
      tag_q.push_back(tag);
      if (!dv)                      m_st = 0;
      else if (skew)                m_st = 2;
      else if (pre && d == 8'hD5)   m_st = 1;
      m_pd  = d;
      m_pdv = dv;
      m_per = er;
   endtask

   task automatic send(input logic [7:0] d, input logic dv, input logic er, input string tag);
      int per;
      per = (cur_spd == 2'b00) ? SLOW_PER : MID_PER;
      if (cur_spd == 2'b10) begin
         @(negedge clk);
         speed_sel  = cur_spd;
         rx_data_in = d;
         rx_dv_in   = dv;
         rx_er_in   = er;
         sample_en  = 1'($urandom % 2);
         tb_eff     = 1'b1;
         model_step(d, dv, er, tag);
      end else begin
         for (int i = 0; i < per; i++) begin
            @(negedge clk);
            speed_sel = cur_spd;
            if (i == per - 1) begin
               rx_data_in = d;
               rx_dv_in   = dv;
               rx_er_in   = er;
               sample_en  = 1'b1;
               tb_eff     = 1'b1;
               model_step(d, dv, er, tag);
            end else begin
               // garbage between samples must not reach the outputs
               rx_data_in = d ^ 8'hA5 ^ 8'(i);
               rx_dv_in   = ~dv;
               rx_er_in   = ~er;
               sample_en  = 1'b0;
               tb_eff     = 1'b0;
            end
         end
      end
   endtask

   task automatic idle_bytes(input int n, input string tag);
      for (int k = 0; k < n; k++) send(8'h00, 1'b0, 1'b0, tag);
   endtask

   // monitor: pops expected results after each sampling edge, checks hold otherwise
   initial begin
      logic was;
      forever begin
         @(posedge clk);
         was = tb_eff && rst_n;
         @(negedge clk);
         if (was) begin
            if (exp_q.size() == 0) begin
               n_chk++;
               n_fail++;
               $display("FAIL R4: output sample with empty scoreboard, got d=%02h expected none", gmii_rxd);
            end else begin
               last_exp = exp_q.pop_front();
               check(tag_q.pop_front(), {gmii_rx_er, gmii_rx_dv, gmii_rxd}, last_exp);
            end
         end else if (rst_n && !done) begin
            check("R3 hold between samples", {gmii_rx_er, gmii_rx_dv, gmii_rxd}, last_exp);
         end
      end
   end

   initial begin
      repeat (WDOG_CYC) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 in reset", {gmii_rx_er, gmii_rx_dv, gmii_rxd}, 10'h000);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R1 after reset", {gmii_rx_er, gmii_rx_dv, gmii_rxd}, 10'h000);

      // full rate, aligned delimiter, error in payload
      cur_spd = 2'b10;
      send(8'h55, 1'b1, 1'b0, "R2 gig preamble");
      send(8'h55, 1'b1, 1'b0, "R2 gig preamble");
      send(8'h55, 1'b1, 1'b0, "R5 gig preamble");
      send(8'hD5, 1'b1, 1'b0, "R5 gig aligned sfd");
      send(8'h11, 1'b1, 1'b0, "R4 gig payload");
      send(8'h22, 1'b1, 1'b1, "R8 gig error");
      send(8'h33, 1'b1, 1'b0, "R4 gig payload");
      idle_bytes(2, "R8 gig end");
      // full rate, skewed delimiter
      send(8'h55, 1'b1, 1'b0, "R6 gig preamble");
      send(8'hAD, 1'b1, 1'b0, "R6 gig skewed sfd");
      send(8'hB2, 1'b1, 1'b0, "R6 gig rebuilt payload");
      idle_bytes(2, "R7 gig end");

      // 100 Mb/s skewed frame, then aligned frame
      cur_spd = 2'b01;
      send(8'h55, 1'b1, 1'b0, "R3 mid preamble");
      send(8'h55, 1'b1, 1'b0, "R6 mid preamble");
      send(8'h3D, 1'b1, 1'b0, "R6 mid skewed sfd");
      send(8'h21, 1'b1, 1'b1, "R8 mid error in shifted frame");
      send(8'hF4, 1'b1, 1'b0, "R6 mid rebuilt payload");
      idle_bytes(2, "R7 mid end of shifted frame");
      send(8'h55, 1'b1, 1'b0, "R7 next frame preamble");
      send(8'hD5, 1'b1, 1'b0, "R7 next frame unshifted");
      send(8'h9A, 1'b1, 1'b0, "R7 next frame payload");
      idle_bytes(2, "R7 mid end");

      // 10 Mb/s, lock then a lookalike pattern
      cur_spd = 2'b00;
      send(8'h55, 1'b1, 1'b0, "R3 slow preamble");
      send(8'hD5, 1'b1, 1'b0, "R5 slow sfd");
      send(8'h55, 1'b1, 1'b0, "R9 slow lookalike");
      send(8'h7D, 1'b1, 1'b0, "R9 slow no realign");
      send(8'h66, 1'b1, 1'b1, "R8 slow error");
      idle_bytes(2, "R8 slow end");

      // reserved speed code follows the enable
      cur_spd = 2'b11;
      send(8'h55, 1'b1, 1'b0, "R3 rsvd preamble");
      send(8'h4D, 1'b1, 1'b0, "R6 rsvd skewed sfd");
      send(8'hC3, 1'b1, 1'b0, "R6 rsvd payload");
      idle_bytes(2, "R3 rsvd end");

      @(negedge clk);
      speed_sel = 2'b00;
      sample_en = 1'b0;
      tb_eff    = 1'b0;
      repeat (3) @(negedge clk);
      done = 1'b1;
      if (exp_q.size() != 0) begin
         n_chk++;
         n_fail++;
         $display("FAIL R4: %0d results never produced, expected 0", exp_q.size());
      end
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule